// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block arbitrates sixteen interrupt request lines split across a master controller (lines 0 to 7) and a slave controller (lines 8 to 15). The slave is chained into master line 2, so its eight lines sit in the global order between master lines 2 and 3. Rising edges on the request inputs are latched as pending requests. Masks, the per-controller special-mask and auto-EOI flags, the two vector bases and the end-of-interrupt strobes all come from an external register interface. The block decodes none of them itself.

While the CPU interrupt enable is high, the block raises a combinational interrupt request for the best qualifying line. A one-cycle acknowledge accepts that line. The acknowledge clears its pending bit, registers its 8-bit vector and, unless that controller is in auto-EOI mode, marks the line in service and makes it the active level. End-of-interrupt strobes retire the active level, and the block then finds the next highest level still in service.

Top module: `cirq_arbiter`

## Requirements
- R1: Among qualifying lines the one granted is the first in the order 0, 1, 2, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.
- R2: A slave line (8 to 15) is eligible only while it is pending, its own mask bit is 0 and mask bit 2 is 0. A mask bit of 1 disables its line.
- R3: With no special mask in effect and a level active, only eligible lines of strictly higher priority than the active level raise `irq_out`. With nothing active, every eligible line qualifies.
- R4: When `special_in[c]` is 1 (c = 0 master, c = 1 slave), eligible lines of controller c qualify whatever the active level is. The flag of the other controller has no effect on them.
- R5: An acknowledge while `irq_out` is 1 clears the granted pending bit. On the next cycle it gives `vec_valid` = 1 for exactly one cycle with `vec_out` = {base[7:3], line[2:0]}. The base is `vec_base_m` for master lines and `vec_base_s` for slave lines.
- R6: When the granting controller has `auto_eoi_in[c]` = 0, the accepted line's `isr_out` bit is set and `act_line` becomes that line with `act_valid` = 1. When `auto_eoi_in[c]` = 1, the in-service state is left unchanged.
- R7: A pulse on `eoi_ns[c]` clears the in-service bit of the active line only when the active line belongs to controller c. The active level then becomes the highest-priority line still in service, or none.
- R8: A pulse on `eoi_sp[c]` with `eoi_lvl` = L clears the active line only when the active line equals c*8+L. The active level is then recomputed as in R7.
- R9: While `cpu_ie` is 0, `irq_out` is 0, an acknowledge is ignored and pending requests are kept.
- R10: A request is latched only on a 0-to-1 transition of its input. It stays pending until accepted, and a line held high is not latched again.
- R11: After reset no request is pending and nothing is in service; `irq_out`, `act_valid` and `vec_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | 16 | Raw request lines, edge-latched |
| mask_in | input | 16 | Per-line mask, 1 disables |
| special_in | input | 2 | Special-mask flag per controller |
| auto_eoi_in | input | 2 | Auto end-of-interrupt flag per controller |
| vec_base_m | input | 8 | Vector base of the master lines |
| vec_base_s | input | 8 | Vector base of the slave lines |
| cpu_ie | input | 1 | CPU interrupt enable |
| eoi_ns | input | 2 | Nonspecific EOI strobe per controller |
| eoi_sp | input | 2 | Specific EOI strobe per controller |
| eoi_lvl | input | 3 | Level within the controller for a specific EOI |
| ack | input | 1 | One-cycle interrupt acknowledge |
| irq_out | output | 1 | Interrupt request to the CPU, combinational |
| vec_out | output | 8 | Vector of the last accepted line |
| vec_valid | output | 1 | One-cycle strobe marking a new vector |
| pend_out | output | 16 | Latched pending requests |
| isr_out | output | 16 | In-service bits |
| act_valid | output | 1 | A level is active |
| act_line | output | 4 | Active in-service line |

## Verification
A rising request edge appears in `pend_out` one clock after it is sampled. `irq_out` follows the latched state and the masks, enables and special flags within the same cycle, with no clock in between. An acknowledge or an EOI strobe changes `vec_out`, `vec_valid`, `isr_out` and `act_line` at the edge that samples it, and `vec_valid` drops one edge later. The bench drives every input just after a falling edge and reads the outputs just after the following falling edge, so each result is checked one register stage after its cause. The combinational request is checked a moment after an input changes.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
    localparam int LPC = 8;
    localparam int CAS = 2;
    localparam int NL  = 2 * LPC;
    localparam int LW  = $clog2(NL);
    localparam int CW  = $clog2(LPC);
    localparam int VW  = 8;

    typedef logic [LW-1:0] line_t;

    typedef struct packed {
        logic [NL-1:0] pend;
        logic [NL-1:0] isr;
        logic [NL-1:0] req_prev;
        logic          act_vld;
        line_t         act;
        logic [VW-1:0] vec;
        logic          vec_vld;
    } state_t;

    // position in the global order, 0 is highest
    function automatic line_t line_rank(line_t ln);
        int i;
        i = int'(ln);
        if (i < LPC) begin
            if (i <= CAS) return ln;
            return line_t'(i + LPC);
        end
        return line_t'(CAS + 1 + i - LPC);
    endfunction

    // line found at a given position of the global order
    function automatic line_t rank_line(int r);
        if (r <= CAS) return line_t'(r);
        if (r <= CAS + LPC) return line_t'(r - CAS - 1 + LPC);
        return line_t'(r - LPC);
    endfunction

    function automatic logic line_ctrl(line_t ln);
        return ln[LW-1];
    endfunction
endpackage

// File: rtl/cirq_rank_pick.sv
module cirq_rank_pick
    import cirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] cand,
    output logic          found,
    output line_t         line
);
    always_comb begin
        found = 1'b0;
        line  = '0;
        for (int r = NL - 1; r >= 0; r--) begin
            if (cand[rank_line(r)]) begin
                found = 1'b1;
                line  = rank_line(r);
            end
        end
    end

    AST_PICK_IS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> cand[line]); // R1
endmodule

// File: rtl/cirq_qualify.sv
module cirq_qualify
    import cirq_pkg::*;
(
    input  logic [NL-1:0] pend,
    input  logic [NL-1:0] mask_in,
    input  logic [1:0]    special_in,
    input  logic          act_vld,
    input  line_t         act,
    output logic [NL-1:0] qual
);
    for (genvar i = 0; i < NL; i++) begin : g_line
        localparam line_t LN = line_t'(i);
        logic gate;
        logic elig;
        if (i < LPC) begin : g_master
            assign gate = 1'b1;
        end else begin : g_slave
            assign gate = ~mask_in[CAS];
        end
        assign elig    = pend[i] & ~mask_in[i] & gate;
        assign qual[i] = elig & (~act_vld | special_in[line_ctrl(LN)]
                                 | (line_rank(LN) < line_rank(act)));
    end
endmodule

// File: rtl/cirq_arbiter.sv
module cirq_arbiter
    import cirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] req_in,
    input  logic [NL-1:0] mask_in,
    input  logic [1:0]    special_in,
    input  logic [1:0]    auto_eoi_in,
    input  logic [VW-1:0] vec_base_m,
    input  logic [VW-1:0] vec_base_s,
    input  logic          cpu_ie,
    input  logic [1:0]    eoi_ns,
    input  logic [1:0]    eoi_sp,
    input  logic [CW-1:0] eoi_lvl,
    input  logic          ack,
    output logic          irq_out,
    output logic [VW-1:0] vec_out,
    output logic          vec_valid,
    output logic [NL-1:0] pend_out,
    output logic [NL-1:0] isr_out,
    output logic          act_valid,
    output line_t         act_line
);
    localparam logic [NL-1:0] ONE = {{(NL-1){1'b0}}, 1'b1};

    state_t s_q, s_d;

    logic [NL-1:0] edge_w;
    logic [NL-1:0] qual_w;
    logic [NL-1:0] cand_w;
    logic          req_found;
    line_t         sel;
    logic          accept;
    logic          eoi_hit;
    logic [NL-1:0] isr_after;
    logic          isr_found;
    line_t         isr_top;
    logic          act_c;

    assign edge_w = req_in & ~s_q.req_prev;

    cirq_qualify u_qual (
        .pend       (s_q.pend),
        .mask_in    (mask_in),
        .special_in (special_in),
        .act_vld    (s_q.act_vld),
        .act        (s_q.act),
        .qual       (qual_w)
    );

    assign cand_w = qual_w & {NL{cpu_ie}};

    cirq_rank_pick u_req_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .cand  (cand_w),
        .found (req_found),
        .line  (sel)
    );

    assign irq_out = req_found;
    assign accept  = ack & req_found;

    assign act_c   = line_ctrl(s_q.act);
    assign eoi_hit = s_q.act_vld &
                     (eoi_ns[act_c] | (eoi_sp[act_c] & (eoi_lvl == s_q.act[CW-1:0])));
    assign isr_after = s_q.isr & ~(eoi_hit ? (ONE << s_q.act) : '0);

    cirq_rank_pick u_isr_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .cand  (isr_after),
        .found (isr_found),
        .line  (isr_top)
    );

    always_comb begin
        s_d          = s_q;
        s_d.req_prev = req_in;
        s_d.pend     = (s_q.pend & ~(accept ? (ONE << sel) : '0)) | edge_w;
        s_d.isr      = isr_after;
        s_d.vec_vld  = accept;
        if (eoi_hit) begin
            s_d.act_vld = isr_found;
            s_d.act     = isr_found ? isr_top : '0;
        end
        if (accept) begin
            if (line_ctrl(sel))
                s_d.vec = {vec_base_s[VW-1:CW], sel[CW-1:0]};
            else
                s_d.vec = {vec_base_m[VW-1:CW], sel[CW-1:0]};
            if (!auto_eoi_in[line_ctrl(sel)]) begin
                s_d.isr[sel] = 1'b1;
                s_d.act_vld  = 1'b1;
                s_d.act      = sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign vec_out   = s_q.vec;
    assign vec_valid = s_q.vec_vld;
    assign pend_out  = s_q.pend;
    assign isr_out   = s_q.isr;
    assign act_valid = s_q.act_vld;
    assign act_line  = s_q.act;

    AST_ACTIVE_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.act_vld |-> s_q.isr[s_q.act]); // R6
    AST_ACCEPT_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !edge_w[sel]) |=> !s_q.pend[$past(sel)]); // R5
    AST_IE_BLOCKS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ie |=> !vec_valid); // R9
    AST_SLAVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && line_ctrl(sel)) |-> !mask_in[CAS]); // R2
    AST_NESTED_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && s_q.act_vld && !special_in[line_ctrl(sel)])
            |-> (line_rank(sel) < line_rank(s_q.act))); // R3
endmodule

// File: tb/cirq_arbiter_bench.sv
module cirq_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_in = '0;
    logic [15:0] mask_in = '0;
    logic [1:0]  special_in = '0;
    logic [1:0]  auto_eoi_in = '0;
    logic [7:0]  vec_base_m = 8'h08;
    logic [7:0]  vec_base_s = 8'h70;
    logic        cpu_ie = 1'b1;
    logic [1:0]  eoi_ns = '0;
    logic [1:0]  eoi_sp = '0;
    logic [2:0]  eoi_lvl = '0;
    logic        ack = 1'b0;
    logic        irq_out;
    logic [7:0]  vec_out;
    logic        vec_valid;
    logic [15:0] pend_out;
    logic [15:0] isr_out;
    logic        act_valid;
    logic [3:0]  act_line;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cirq_arbiter u_cirq_arbiter (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask_in(mask_in),
        .special_in(special_in), .auto_eoi_in(auto_eoi_in),
        .vec_base_m(vec_base_m), .vec_base_s(vec_base_s), .cpu_ie(cpu_ie),
        .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_lvl(eoi_lvl), .ack(ack),
        .irq_out(irq_out), .vec_out(vec_out), .vec_valid(vec_valid),
        .pend_out(pend_out), .isr_out(isr_out), .act_valid(act_valid),
        .act_line(act_line)
    );

    function automatic int brank(int i);
        if (i < 3) return i;
        if (i >= 8) return i - 5;
        return i + 8;
    endfunction

    function automatic int bvec(int ln);
        return (ln < 8) ? (8'h08 + ln) : (8'h70 + ln - 8);
    endfunction

    task automatic chk(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic pulse(logic [15:0] m);
        req_in = m; step(); req_in = '0; step();
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic eoi_n(int c);
        eoi_ns[c] = 1'b1; step(); eoi_ns = '0;
    endtask

    task automatic eoi_s(int c, int l);
        eoi_sp[c] = 1'b1; eoi_lvl = 3'(l); step(); eoi_sp = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        step();
        chk("R11 irq", int'(irq_out), 0);
        chk("R11 pend", int'(pend_out), 0);
        chk("R11 isr", int'(isr_out), 0);
        chk("R11 act_valid", int'(act_valid), 0);
        chk("R11 vec_valid", int'(vec_valid), 0);

        // single line sweep
        for (int ln = 0; ln < 16; ln++) begin
            pulse(16'(1) << ln);
            chk("R10 pend latched", int'(pend_out), 1 << ln);
            chk("R3 irq idle", int'(irq_out), 1);
            do_ack();
            chk("R5 vector", int'(vec_out), bvec(ln));
            chk("R5 vec_valid", int'(vec_valid), 1);
            chk("R5 pend cleared", int'(pend_out), 0);
            chk("R6 isr", int'(isr_out), 1 << ln);
            chk("R6 act_line", int'(act_line), ln);
            step();
            chk("R5 vec_valid one cycle", int'(vec_valid), 0);
            eoi_n(ln / 8);
            chk("R7 isr cleared", int'(isr_out), 0);
            chk("R7 none active", int'(act_valid), 0);
        end

        // pairwise priority sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = a + 1; b < 16; b++) begin
                int w, l;
                w = (brank(a) < brank(b)) ? a : b;
                l = (w == a) ? b : a;
                pulse((16'(1) << a) | (16'(1) << b));
                do_ack();
                chk("R1 winner vector", int'(vec_out), bvec(w));
                chk("R3 lower blocked", int'(irq_out), 0);
                eoi_n(w / 8);
                chk("R7 back to idle", int'(act_valid), 0);
                chk("R3 loser now served", int'(irq_out), 1);
                do_ack();
                chk("R1 loser vector", int'(vec_out), bvec(l));
                eoi_n(l / 8);
                chk("R7 clean", int'(isr_out), 0);
            end
        end

        // preemption and EOI recomputation
        pulse(16'h0080); do_ack();
        pulse(16'h0001);
        chk("R3 higher preempts", int'(irq_out), 1);
        do_ack();
        chk("R6 nested act", int'(act_line), 0);
        chk("R6 nested isr", int'(isr_out), 16'h0081);
        eoi_n(1);
        chk("R7 wrong controller ignored", int'(isr_out), 16'h0081);
        chk("R7 wrong controller act", int'(act_line), 0);
        eoi_n(0);
        chk("R7 recompute act", int'(act_line), 7);
        chk("R7 recompute valid", int'(act_valid), 1);
        eoi_s(0, 3);
        chk("R8 level mismatch", int'(isr_out), 16'h0080);
        eoi_s(1, 7);
        chk("R8 controller mismatch", int'(isr_out), 16'h0080);
        eoi_s(0, 7);
        chk("R8 match clears", int'(isr_out), 0);
        chk("R8 none active", int'(act_valid), 0);

        pulse(16'h0008); do_ack();
        pulse(16'h1000);
        chk("R3 slave above line 3", int'(irq_out), 1);
        do_ack();
        chk("R6 slave act", int'(act_line), 12);
        eoi_s(1, 4);
        chk("R8 recompute to 3", int'(act_line), 3);
        eoi_n(0);
        chk("R7 clean again", int'(act_valid), 0);

        // slave gating
        mask_in = 16'h0004;
        pulse(16'h0200);
        chk("R2 gated by line 2 mask", int'(irq_out), 0);
        chk("R2 still pending", int'(pend_out), 16'h0200);
        mask_in = 16'h0000; #1;
        chk("R2 ungated", int'(irq_out), 1);
        mask_in = 16'h0200; #1;
        chk("R2 own mask", int'(irq_out), 0);
        mask_in = 16'h0000;
        do_ack();
        chk("R2 vector", int'(vec_out), 8'h71);
        eoi_n(1);

        // special mask mode
        pulse(16'h0008); do_ack();
        pulse(16'h0020);
        chk("R4 normal blocks", int'(irq_out), 0);
        special_in = 2'b10; #1;
        chk("R4 other controller flag", int'(irq_out), 0);
        special_in = 2'b01; #1;
        chk("R4 special admits", int'(irq_out), 1);
        do_ack();
        chk("R4 vector", int'(vec_out), 8'h0D);
        chk("R4 isr", int'(isr_out), 16'h0028);
        special_in = 2'b00;
        eoi_n(0);
        chk("R7 after special", int'(act_line), 3);
        eoi_n(0);
        chk("R7 after special idle", int'(act_valid), 0);

        // auto EOI
        auto_eoi_in = 2'b01;
        pulse(16'h0010); do_ack();
        chk("R6 auto vector", int'(vec_out), 8'h0C);
        chk("R6 auto isr", int'(isr_out), 0);
        chk("R6 auto act", int'(act_valid), 0);
        auto_eoi_in = 2'b10;
        pulse(16'h0400); do_ack();
        chk("R6 auto slave vector", int'(vec_out), 8'h72);
        chk("R6 auto slave isr", int'(isr_out), 0);
        auto_eoi_in = 2'b00;

        // interrupt enable
        cpu_ie = 1'b0;
        pulse(16'h0002);
        chk("R9 irq low", int'(irq_out), 0);
        do_ack();
        chk("R9 ack ignored", int'(vec_valid), 0);
        chk("R9 pending kept", int'(pend_out), 16'h0002);
        cpu_ie = 1'b1; #1;
        chk("R9 irq after enable", int'(irq_out), 1);
        do_ack();
        chk("R9 vector", int'(vec_out), 8'h09);
        eoi_n(0);

        // level held high latches once
        req_in = 16'h0040; step(); step();
        do_ack();
        chk("R10 accepted", int'(vec_out), 8'h0E);
        eoi_n(0);
        step();
        chk("R10 no relatch pend", int'(pend_out), 0);
        chk("R10 no relatch irq", int'(irq_out), 0);
        req_in = '0; step();
        req_in = 16'h0040; step();
        chk("R10 new edge", int'(pend_out), 16'h0040);
        req_in = '0;
        do_ack(); eoi_n(0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule